// File: doc/BRIEF.md
# Branch Condition and Target Unit

A purely combinational resolver for the branch group of a compact 16-bit instruction encoding. It takes the halfword being executed, the halfword that follows it, the program counter value and the four condition flags. It decides whether control transfers, where it goes and whether the return-address register is written. Instruction fetch and flag generation sit outside the block. The program counter input is already advanced 4 bytes past the halfword under decode.

Four families are resolved: flag-conditioned short branches, unconditional short branches, two-halfword calls and register-indirect branches with optional link. For register-indirect branches the unit drives a register index out and receives that register's value back on a read port in the same cycle. It flags malformed encodings on a separate output instead of branching, and it reports when a register-indirect target is the special return-from-exception pattern.

Top module: `bru_unit`

## Requirements
- R1: A halfword with bits [15:12] = 0xD and index bits [11:8] in 0..7 is taken when its flag test holds. Index 0 tests Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0. The flag input is ordered {N,Z,C,V}, with N in bit 3. This family never writes the link register.
- R2: Indices 8..13 in the same range use compound tests. 8 needs C=1 and Z=0. 9 needs C=0 or Z=1. 10 needs N=V. 11 needs N≠V. 12 needs Z=0 and N=V. 13 needs Z=1 or N≠V.
- R3: The conditional target is the PC plus the sign-extended bits [7:0] shifted left by one.
- R4: Halfwords 0xE000–0xE7FF are always taken with target PC + (sign-extended bits [10:0] << 1), and write no link.
- R5: A first halfword in 0xF000–0xF7FF whose following halfword has bits [15:13] = 3'b111 is a call. Its target is PC + (sign-extended first [10:0] << 12) + (following [10:0] << 1).
- R6: A well-formed call writes the link register with PC OR 1.
- R7: A halfword with bits [15:8] = 0x47 places bits [6:3] on the register index output and branches to the returned register value with bit 0 cleared.
- R8: In that family, bit 7 set raises the link write with value (PC − 2) OR 1. Bit 7 clear raises no link write.
- R9: When the register value's bits above [3:0] are all ones, the branch is an exception return. With bits [3:0] = 4'b1001 the exception-return output and taken are raised. With any other nibble the branch is illegal.
- R10: The illegal output is raised for a call whose following halfword lacks the three top ones, and for indices 14 and 15 in the conditional range. When illegal is raised, taken and link write are low.
- R11: Any halfword outside these families gives taken, link write, illegal and exception return all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_hw | input | 16 | Halfword under decode |
| follow_hw | input | 16 | Halfword after it (second half of a call) |
| pc_cur | input | PC_W | Program counter, 4 bytes past instr_hw |
| flags_nzcv | input | 4 | Condition flags {N,Z,C,V} |
| src_val | input | PC_W | Value of the register selected by src_idx |
| src_idx | output | 4 | Register index for the indirect branch |
| taken | output | 1 | Control transfers to target |
| target | output | PC_W | Branch destination |
| link_we | output | 1 | Write enable for the link register |
| link_val | output | PC_W | Value for the link register |
| exc_return | output | 1 | Indirect branch is a return from exception |
| illegal | output | 1 | Malformed branch encoding |

## Verification
The hardest state to reach from the ports is the exception-return window. It needs a register-indirect halfword together with a register value whose upper 28 bits are all ones, and random 32-bit values essentially never produce that. The stimulus therefore forces that upper pattern in a quarter of the indirect cases, and picks the low nibble either as the legal code or at random. The conditional family is swept exhaustively over all sixteen indices and all sixteen flag combinations, with random offsets and PCs. Malformed call tails are injected on purpose.

// File: rtl/bru_pkg.sv
// Shared types for the branch unit.
// Assumes halfword-wide instruction encodings.
package bru_pkg;
    localparam int HW_W   = 16;
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef enum logic [2:0] {
        BK_NONE   = 3'd0,
        BK_COND   = 3'd1,
        BK_UNCOND = 3'd2,
        BK_CALL   = 3'd3,
        BK_REG    = 3'd4
    } br_kind_e;
endpackage

// File: rtl/bru_decode.sv
// Classifies a halfword into a branch family and extracts its fields.
// Assumes the caller supplies the halfword after it for call checking.
module bru_decode
    import bru_pkg::*;
(
    input  logic [HW_W-1:0] hw,
    input  logic [HW_W-1:0] nxt,
    output br_kind_e        kind,
    output logic [3:0]      cond_idx,
    output logic [3:0]      reg_idx,
    output logic            link_req,
    output logic            tail_ok,
    output logic [7:0]      imm8,
    output logic [10:0]     imm11,
    output logic [10:0]     tail_imm
);
    logic unused_tail;

    // family selection from the top bits
    always_comb begin
        kind = BK_NONE;
        if (hw[15:12] == 4'hD)           kind = BK_COND;
        else if (hw[15:11] == 5'b11100)  kind = BK_UNCOND;
        else if (hw[15:11] == 5'b11110)  kind = BK_CALL;
        else if (hw[15:8] == 8'h47)      kind = BK_REG;
    end

    // field extraction
    assign cond_idx    = hw[11:8];
    assign reg_idx     = hw[6:3];
    assign link_req    = hw[7];
    assign imm8        = hw[7:0];
    assign imm11       = hw[10:0];
    assign tail_ok     = &nxt[15:13];
    assign tail_imm    = nxt[10:0];
    assign unused_tail = ^{hw[2:0], nxt[12:11]};
endmodule

// File: rtl/bru_cond.sv
// Evaluates a 4-bit condition index against the flags.
// Indices 14 and 15 are reported as bad codes.
module bru_cond
    import bru_pkg::*;
(
    input  logic [3:0] idx,
    input  logic [3:0] flags,
    output logic       pass,
    output logic       bad_code
);
    logic n, z, c, v;
    logic [15:0] tests;

    assign n = flags[FLAG_N];
    assign z = flags[FLAG_Z];
    assign c = flags[FLAG_C];
    assign v = flags[FLAG_V];

    // simple flag tests come in true/false pairs
    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_pair
            logic f;
            assign f = (g == 0) ? z : (g == 1) ? c : (g == 2) ? n : v;
            assign tests[2*g]     = f;
            assign tests[2*g + 1] = ~f;
        end
    endgenerate

    // compound tests
    always_comb begin
        tests[8]  = c & ~z;
        tests[9]  = ~c | z;
        tests[10] = (n == v);
        tests[11] = (n != v);
        tests[12] = ~z & (n == v);
        tests[13] = z | (n != v);
        tests[14] = 1'b0;
        tests[15] = 1'b0;
    end

    assign pass     = tests[idx];
    assign bad_code = (idx == 4'hE) || (idx == 4'hF);
endmodule

// File: rtl/bru_target.sv
// Computes branch destination and link value for each family.
// Assumes PC_W >= 23 so the call offset fits.
module bru_target
    import bru_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  br_kind_e        kind,
    input  logic [7:0]      imm8,
    input  logic [10:0]     imm11,
    input  logic [10:0]     tail_imm,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] rs,
    output logic [PC_W-1:0] dest,
    output logic [PC_W-1:0] link
);
    localparam int PAD8  = PC_W - 9;
    localparam int PAD11 = PC_W - 12;
    localparam int PADHI = PC_W - 23;

    logic [PC_W-1:0] off_cond, off_short, off_hi, off_lo;

    // offsets scaled to byte addresses
    assign off_cond  = {{PAD8{imm8[7]}}, imm8, 1'b0};
    assign off_short = {{PAD11{imm11[10]}}, imm11, 1'b0};
    assign off_hi    = {{PADHI{imm11[10]}}, imm11, 12'b0};
    assign off_lo    = {{PAD11{1'b0}}, tail_imm, 1'b0};

    // destination per family
    always_comb begin
        unique case (kind)
            BK_COND:   dest = pc + off_cond;
            BK_UNCOND: dest = pc + off_short;
            BK_CALL:   dest = pc + off_hi + off_lo;
            BK_REG:    dest = {rs[PC_W-1:1], 1'b0};
            default:   dest = '0;
        endcase
    end

    // return address with the mode bit set
    always_comb begin
        if (kind == BK_REG) link = (pc - PC_W'(2)) | PC_W'(1);
        else                link = pc | PC_W'(1);
    end
endmodule

// File: rtl/bru_unit.sv
// Branch condition and target unit, top level.
// Purely combinational; pc_cur is 4 bytes past instr_hw.
module bru_unit
    import bru_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [15:0]     instr_hw,
    input  logic [15:0]     follow_hw,
    input  logic [PC_W-1:0] pc_cur,
    input  logic [3:0]      flags_nzcv,
    input  logic [PC_W-1:0] src_val,
    output logic [3:0]      src_idx,
    output logic            taken,
    output logic [PC_W-1:0] target,
    output logic            link_we,
    output logic [PC_W-1:0] link_val,
    output logic            exc_return,
    output logic            illegal
);
    localparam logic [3:0] EXC_CODE = 4'b1001;

    br_kind_e    kind;
    logic [3:0]  cond_idx;
    logic        link_req, tail_ok, cond_pass, cond_bad;
    logic [7:0]  imm8;
    logic [10:0] imm11, tail_imm;
    logic        exc_pat, exc_ok;

    bru_decode u_dec (
        .hw(instr_hw), .nxt(follow_hw), .kind(kind), .cond_idx(cond_idx),
        .reg_idx(src_idx), .link_req(link_req), .tail_ok(tail_ok),
        .imm8(imm8), .imm11(imm11), .tail_imm(tail_imm)
    );

    bru_cond u_cond (
        .idx(cond_idx), .flags(flags_nzcv), .pass(cond_pass), .bad_code(cond_bad)
    );

    bru_target #(.PC_W(PC_W)) u_tgt (
        .kind(kind), .imm8(imm8), .imm11(imm11), .tail_imm(tail_imm),
        .pc(pc_cur), .rs(src_val), .dest(target), .link(link_val)
    );

    // exception-return pattern on the register value
    assign exc_pat = &src_val[PC_W-1:4];
    assign exc_ok  = (src_val[3:0] == EXC_CODE);

    // final resolution of taken, link, illegal
    always_comb begin
        taken      = 1'b0;
        link_we    = 1'b0;
        illegal    = 1'b0;
        exc_return = 1'b0;
        unique case (kind)
            BK_COND: begin
                illegal = cond_bad;
                taken   = cond_pass & ~cond_bad;
            end
            BK_UNCOND: taken = 1'b1;
            BK_CALL: begin
                illegal = ~tail_ok;
                taken   = tail_ok;
                link_we = tail_ok;
            end
            BK_REG: begin
                illegal    = exc_pat & ~exc_ok;
                taken      = ~illegal;
                link_we    = link_req & ~illegal;
                exc_return = exc_pat & exc_ok;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bru_unit_chk.sv
// Property checker for bru_unit, attached by bind.
// Uses immediate assertions since the unit has no clock.
module bru_unit_chk #(
    parameter int PC_W = 32
) (
    input logic [15:0]     instr_hw,
    input logic [PC_W-1:0] src_val,
    input logic            taken,
    input logic [PC_W-1:0] target,
    input logic            link_we,
    input logic [PC_W-1:0] link_val,
    input logic            exc_return,
    input logic            illegal
);
    logic in_cond, in_short, in_call, in_reg;

    assign in_cond  = instr_hw[15:12] == 4'hD;
    assign in_short = instr_hw[15:11] == 5'b11100;
    assign in_call  = instr_hw[15:11] == 5'b11110;
    assign in_reg   = instr_hw[15:8] == 8'h47;

    // checks on the resolved outputs
    always_comb begin
        AST_COND_NO_LINK: assert (!in_cond || !link_we);                      // R1
        AST_SHORT_ALWAYS: assert (!in_short || (taken && !link_we));          // R4
        AST_LINK_ODD: assert (!link_we || link_val[0]);                       // R6
        AST_REG_EVEN: assert (!(in_reg && taken) || !target[0]);              // R7
        AST_NO_LINK_BIT7: assert (!(in_reg && !instr_hw[7]) || !link_we);     // R8
        AST_EXC_CODE: assert (!exc_return || (taken && src_val[3:0] == 4'b1001)); // R9
        AST_ILL_QUIET: assert (!illegal || (!taken && !link_we));             // R10
        AST_OTHER_IDLE: assert ((in_cond || in_short || in_call || in_reg) ||
                                (!taken && !link_we && !illegal && !exc_return)); // R11
    end
endmodule

bind bru_unit bru_unit_chk #(.PC_W(PC_W)) u_chk (
    .instr_hw(instr_hw), .src_val(src_val), .taken(taken), .target(target),
    .link_we(link_we), .link_val(link_val), .exc_return(exc_return),
    .illegal(illegal)
);

// File: tb/bru_unit_tb_top.sv
// Self-checking bench for bru_unit: exhaustive condition sweep,
// random families and directed corners against a bench model.
module bru_unit_tb_top;
    logic        clk = 1'b0;
    logic [15:0] instr_hw, follow_hw;
    logic [31:0] pc_cur, src_val, target, link_val;
    logic [3:0]  flags_nzcv, src_idx;
    logic        taken, link_we, exc_return, illegal;
    int          n_chk = 0, n_bad = 0;
    int unsigned seed_init;

    always #2 clk = ~clk;

    bru_unit #(.PC_W(32)) dut_i (
        .instr_hw(instr_hw), .follow_hw(follow_hw), .pc_cur(pc_cur),
        .flags_nzcv(flags_nzcv), .src_val(src_val), .src_idx(src_idx),
        .taken(taken), .target(target), .link_we(link_we),
        .link_val(link_val), .exc_return(exc_return), .illegal(illegal)
    );

    function automatic logic cond_ok(input logic [3:0] i, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (i)
            4'd0: return z;        4'd1: return !z;
            4'd2: return c;        4'd3: return !c;
            4'd4: return n;        4'd5: return !n;
            4'd6: return v;        4'd7: return !v;
            4'd8: return c && !z;  4'd9: return !c || z;
            4'd10: return n == v;  4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b0;
        endcase
    endfunction

    // drive one vector, compute the expectation, compare
    task automatic run_one(input logic [15:0] h, input logic [15:0] nh,
                           input logic [31:0] pc, input logic [3:0] f,
                           input logic [31:0] rs, input string tag);
        logic e_tk, e_lw, e_ex, e_il;
        logic [31:0] e_tg, e_lv;
        logic bad;
        e_tk = 0; e_lw = 0; e_ex = 0; e_il = 0; e_tg = 0; e_lv = 0;
        if (h[15:12] == 4'hD) begin
            e_il = h[11:8] >= 4'hE;
            e_tk = !e_il && cond_ok(h[11:8], f);
            e_tg = pc + {{23{h[7]}}, h[7:0], 1'b0};
        end else if (h[15:11] == 5'b11100) begin
            e_tk = 1;
            e_tg = pc + {{20{h[10]}}, h[10:0], 1'b0};
        end else if (h[15:11] == 5'b11110) begin
            e_il = nh[15:13] != 3'b111;
            e_tk = !e_il; e_lw = !e_il;
            e_tg = pc + {{9{h[10]}}, h[10:0], 12'b0} + {20'b0, nh[10:0], 1'b0};
            e_lv = pc | 32'd1;
        end else if (h[15:8] == 8'h47) begin
            e_il = (rs[31:4] == 28'hFFFFFFF) && (rs[3:0] != 4'b1001);
            e_ex = (rs[31:4] == 28'hFFFFFFF) && (rs[3:0] == 4'b1001);
            e_tk = !e_il; e_lw = h[7] && !e_il;
            e_tg = rs & ~32'd1;
            e_lv = (pc - 32'd2) | 32'd1;
        end
        @(negedge clk);
        instr_hw = h; follow_hw = nh; pc_cur = pc; flags_nzcv = f; src_val = rs;
        #1;
        bad = (taken !== e_tk) || (link_we !== e_lw) || (illegal !== e_il) ||
              (exc_return !== e_ex) ||
              (e_tk && target !== e_tg) || (e_lw && link_val !== e_lv) ||
              (h[15:8] == 8'h47 && src_idx !== h[6:3]);
        n_chk++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s hw=%h: got tk=%b tg=%h lw=%b lv=%h ex=%b il=%b idx=%h exp tk=%b tg=%h lw=%b lv=%h ex=%b il=%b idx=%h",
                     tag, h, taken, target, link_we, link_val, exc_return, illegal, src_idx,
                     e_tk, e_tg, e_lw, e_lv, e_ex, e_il, h[6:3]);
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        seed_init = $urandom(32'd1234);
        instr_hw = 16'hBF00; follow_hw = 0; pc_cur = 0; flags_nzcv = 0; src_val = 0;
        // idle halfword R11
        run_one(16'hBF00, 16'h0000, 32'h100, 4'hF, 32'h0, "R11");
        // exhaustive condition sweep R1 R2 R3 R10
        for (int i = 0; i < 16; i++)
            for (int f = 0; f < 16; f++)
                run_one({4'hD, 4'(i), 8'($urandom())}, 16'($urandom()), $urandom() & ~32'd1,
                        4'(f), $urandom(), i < 8 ? "R1 R3" : (i < 14 ? "R2 R3" : "R10"));
        // offset extremes R3 R4 R5
        run_one(16'hD080, 16'h0, 32'h0000_0100, 4'b0100, 0, "R3");
        run_one(16'hD17F, 16'h0, 32'hFFFF_FFF0, 4'b0000, 0, "R3");
        run_one(16'hE400, 16'h0, 32'h0000_0800, 4'h0, 0, "R4");
        run_one(16'hE3FF, 16'h0, 32'h1000_0000, 4'h0, 0, "R4");
        run_one(16'hF400, 16'hF800, 32'h0040_0004, 4'h0, 0, "R5 R6");
        run_one(16'hF3FF, 16'hFFFF, 32'h0000_0004, 4'h0, 0, "R5 R6");
        run_one(16'hF000, 16'hD800, 32'h0000_0004, 4'h0, 0, "R10");
        // register branch corners R7 R8 R9
        run_one(16'h4770, 16'h0, 32'h200, 4'h0, 32'h0000_1235, "R7");
        run_one(16'h47F0, 16'h0, 32'h200, 4'h0, 32'h0000_1235, "R8");
        run_one(16'h4770, 16'h0, 32'h200, 4'h0, 32'hFFFF_FFF9, "R9");
        run_one(16'h4770, 16'h0, 32'h200, 4'h0, 32'hFFFF_FFF1, "R9");
        run_one(16'h47C8, 16'h0, 32'h200, 4'h0, 32'hFFFF_FFFD, "R9 R10");
        // random families
        for (int k = 0; k < 3000; k++) begin
            int sel = int'($urandom() % 5);
            logic [15:0] h, nh;
            logic [31:0] rs;
            nh = 16'($urandom());
            rs = $urandom();
            case (sel)
                0: h = {5'b11100, 11'($urandom())};
                1: begin
                    h = {5'b11110, 11'($urandom())};
                    if ($urandom() % 4 != 0) nh[15:13] = 3'b111;
                end
                2: begin
                    h = {8'h47, 8'($urandom())};
                    if ($urandom() % 4 == 0) begin
                        rs[31:4] = 28'hFFFFFFF;
                        if ($urandom() % 2 == 0) rs[3:0] = 4'b1001;
                    end
                end
                3: h = {4'hD, 12'($urandom())};
                default: begin
                    h = 16'($urandom());
                    if (h[15:12] == 4'hD || h[15:11] == 5'b11100 ||
                        h[15:11] == 5'b11110 || h[15:8] == 8'h47) h[15:12] = 4'h2;
                end
            endcase
            run_one(h, nh, $urandom() & ~32'd1, 4'($urandom()), rs,
                    sel == 0 ? "R4" : sel == 1 ? "R5 R6 R10" : sel == 2 ? "R7 R8 R9" :
                    sel == 3 ? "R1 R2 R3" : "R11");
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule